// File: doc/BRIEF.md
# Asynchronous Serial Frame Engine

This block is the bit-level core of a serial port. On the transmit side it takes characters from a first-word-fall-through transmit queue, one per frame. It sends each one as a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. It paces the line with a one-per-bit tick. On the receive side it watches the incoming line with a tick at sixteen times the bit rate. It checks each start bit at its midpoint and samples every later bit at mid-bit. Each character it rebuilds goes into the receive queue together with a parity-error flag and a frame-error flag.

Frame shape comes from a slice of the port's control word, bits 21 down to 15. This slice selects the data length, parity enable and sense, the stop length, and whether the transmitter waits for the peer's clear-to-send input. Baud generation, the queues themselves and the register decode sit outside the block. A port counts as drained only when its transmit queue is empty and the busy output is low.

Top module: `uart_frame_engine`

## Requirements
- R1: After reset `txd` is high, `tx_busy` is low, and neither `tx_pop` nor `rx_push` is asserted until the block has work.
- R2: A transmitted frame is a start bit of 0, then N data bits sent least significant bit first, where `ctrl_bits[21:20]` 00/01/10/11 gives N = 8/7/6/5. Data bits above N are ignored. Each bit lasts exactly one `bit_tick` period, and the line stays high between frames.
- R3: When `ctrl_bits[19]` is 1, a parity bit follows the data bits. It makes the count of ones odd when `ctrl_bits[18]` is 1 and even when it is 0. When `ctrl_bits[19]` is 0, no parity bit is sent.
- R4: `ctrl_bits[17:16]` = 00 sends one stop bit (1). Any other value sends two.
- R5: `tx_pop` is asserted only in a cycle with `bit_tick` high and `tx_empty` low. When it is, that same tick starts the start bit. `tx_busy` rises with the start bit and stays high until the `bit_tick` that ends the last stop bit. A character that is waiting at that tick starts the next frame with no idle gap.
- R6: With `ctrl_bits[15]` = 0, no new frame starts while `cts` is low. A frame that is already running finishes. With `ctrl_bits[15]` = 1, `cts` has no effect.
- R7: The receiver samples each bit at its midpoint on `os_tick` (16 per bit). It pushes one character per frame with the data right-aligned and unused upper bits 0. Data length, parity and stop settings come from the same control fields as the transmitter.
- R8: A received parity bit that disagrees with the selected sense sets `rx_perr` on the pushed character. The character is still pushed.
- R9: A low stop bit sets `rx_ferr` on the pushed character. A line held low for a whole frame (a break) is pushed as data 0 with `rx_ferr` set. After a frame error the receiver waits for the line to return high before it looks for a new start bit.
- R10: A start bit that is no longer low at its midpoint is rejected. Nothing is pushed, and the next valid frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per transmit bit period |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate, for the receiver |
| ctrl_bits | input | 7 ([21:15]) | Frame-control slice: length [21:20], parity enable [19], odd sense [18], stop length [17:16], two-wire [15] |
| cts | input | 1 | Peer clear-to-send, high means ready |
| tx_empty | input | 1 | Transmit queue holds no character |
| tx_data | input | 8 | Head of the transmit queue |
| tx_pop | output | 1 | Takes the head character this cycle |
| txd | output | 1 | Serial transmit line |
| tx_busy | output | 1 | High while a frame is on the line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_push | output | 1 | One-cycle strobe: write a received character |
| rx_data | output | 8 | Received character, right-aligned |
| rx_perr | output | 1 | Parity error for the pushed character |
| rx_ferr | output | 1 | Frame error (low stop bit or break) |

## Verification
The properties assume that `bit_tick` and `os_tick` are single-cycle pulses and that `tx_data` is valid whenever `tx_empty` is low. They also assume that the control slice changes only while both directions are idle, because the engine latches it at frame start. The stimulus derives both ticks from one free-running counter, one bit per 32 clocks with `os_tick` every second clock. It drives the receive line at exactly sixteen `os_tick` periods per bit. It reprograms the control slice only after draining every queued transmit character and every expected receive character.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

    // Field positions inside the frame-control slice.
    localparam int CTRL_MSB  = 21;
    localparam int CTRL_LSB  = 15;
    localparam int LEN_HI    = 21;
    localparam int LEN_LO    = 20;
    localparam int PAR_EN    = 19;
    localparam int PAR_ODD   = 18;
    localparam int STOP_HI   = 17;
    localparam int STOP_LO   = 16;
    localparam int TWO_WIRE  = 15;

    localparam int CHAR_W    = 8;
    localparam int NB_W      = 4;

    typedef struct packed {
        logic [NB_W-1:0] nbits;
        logic            par_en;
        logic            par_odd;
        logic            two_stop;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_st_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
    } rx_st_e;

endpackage

// File: rtl/uart_fe_ctrl.sv
module uart_fe_ctrl
    import uart_fe_pkg::*;
(
    input  logic [CTRL_MSB:CTRL_LSB] ctrl_bits,
    input  logic                     cts,
    output frame_cfg_t               cfg,
    output logic                     flow_ok
);
    always_comb begin
        // Reversed length code: 00 -> 8 bits ... 11 -> 5 bits.
        cfg.nbits    = NB_W'(CHAR_W) - {2'b00, ctrl_bits[LEN_HI:LEN_LO]};
        cfg.par_en   = ctrl_bits[PAR_EN];
        cfg.par_odd  = ctrl_bits[PAR_ODD];
        cfg.two_stop = |ctrl_bits[STOP_HI:STOP_LO];
        flow_ok      = ctrl_bits[TWO_WIRE] | cts;
    end
endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
    import uart_fe_pkg::*;
#(
    parameter int DW = CHAR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  frame_cfg_t    cfg_i,
    input  logic          flow_ok,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_data,
    output logic          fifo_pop,
    output logic          txd,
    output logic          busy
);
    typedef struct packed {
        tx_st_e          st;
        logic [DW-1:0]   sh;
        logic [NB_W-1:0] idx;
        logic            par;
        logic            stop2;
        frame_cfg_t      cfg;
        logic            txd;
    } tx_reg_t;

    localparam tx_reg_t TX_RST = '{st: TX_IDLE, sh: '0, idx: '0, par: 1'b0,
                                   stop2: 1'b0, cfg: '0, txd: 1'b1};

    tx_reg_t q, d;
    logic    can_go;
    logic    load;

    assign can_go = !fifo_empty && flow_ok;

    always_comb begin
        d    = q;
        load = 1'b0;
        if (bit_tick) begin
            unique case (q.st)
                TX_IDLE: load = can_go;
                TX_START: begin
                    d.st  = TX_DATA;
                    d.txd = q.sh[0];
                    d.par = q.sh[0];
                    d.sh  = q.sh >> 1;
                    d.idx = NB_W'(1);
                end
                TX_DATA: begin
                    if (q.idx < q.cfg.nbits) begin
                        d.txd = q.sh[0];
                        d.par = q.par ^ q.sh[0];
                        d.sh  = q.sh >> 1;
                        d.idx = q.idx + NB_W'(1);
                    end else if (q.cfg.par_en) begin
                        d.st  = TX_PAR;
                        d.txd = q.par ^ q.cfg.par_odd;
                    end else begin
                        d.st    = TX_STOP;
                        d.txd   = 1'b1;
                        d.stop2 = 1'b0;
                    end
                end
                TX_PAR: begin
                    d.st    = TX_STOP;
                    d.txd   = 1'b1;
                    d.stop2 = 1'b0;
                end
                TX_STOP: begin
                    if (q.cfg.two_stop && !q.stop2) begin
                        d.stop2 = 1'b1;
                    end else if (can_go) begin
                        load = 1'b1;
                    end else begin
                        d.st  = TX_IDLE;
                        d.txd = 1'b1;
                    end
                end
                default: d = TX_RST;
            endcase
        end
        if (load) begin
            d.st  = TX_START;
            d.txd = 1'b0;
            d.sh  = fifo_data;
            d.cfg = cfg_i;
            d.idx = '0;
            d.par = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TX_RST;
        else        q <= d;
    end

    assign fifo_pop = load;
    assign txd      = q.txd;
    assign busy     = (q.st != TX_IDLE);
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
    import uart_fe_pkg::*;
#(
    parameter int DW   = CHAR_W,
    parameter int OS   = 16,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rxd,
    input  frame_cfg_t    cfg_i,
    output logic          push,
    output logic [DW-1:0] data,
    output logic          perr,
    output logic          ferr
);
    localparam int              CNTW = $clog2(OS);
    localparam int              IW   = $clog2(DW);
    localparam logic [CNTW-1:0] HALF = CNTW'(OS / 2 - 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(OS - 1);

    typedef struct packed {
        rx_st_e          st;
        logic [SYNC-1:0] sync;
        logic [CNTW-1:0] cnt;
        logic [IW-1:0]   idx;
        logic [DW-1:0]   data;
        logic            par;
        logic            stop2;
        frame_cfg_t      cfg;
        logic            push;
        logic            perr;
        logic            ferr;
    } rx_reg_t;

    localparam rx_reg_t RX_RST = '{st: RX_IDLE, sync: '1, cnt: '0, idx: '0,
                                   data: '0, par: 1'b0, stop2: 1'b0, cfg: '0,
                                   push: 1'b0, perr: 1'b0, ferr: 1'b0};

    rx_reg_t q, d;
    logic    rxs;

    assign rxs = q.sync[SYNC-1];

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC-2:0], rxd};
        d.push = 1'b0;
        if (os_tick) begin
            unique case (q.st)
                RX_IDLE: begin
                    if (!rxs) begin
                        d.st  = RX_START;
                        d.cnt = '0;
                        d.cfg = cfg_i;
                    end
                end
                RX_START: begin
                    if (q.cnt == HALF) begin
                        if (!rxs) begin
                            d.st   = RX_DATA;
                            d.cnt  = '0;
                            d.idx  = '0;
                            d.data = '0;
                            d.par  = 1'b0;
                            d.perr = 1'b0;
                            d.ferr = 1'b0;
                        end else begin
                            d.st = RX_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + CNTW'(1);
                    end
                end
                RX_DATA: begin
                    if (q.cnt == LAST) begin
                        d.cnt         = '0;
                        d.data[q.idx] = rxs;
                        d.par         = q.par ^ rxs;
                        if (NB_W'(q.idx) == q.cfg.nbits - NB_W'(1)) begin
                            d.st    = q.cfg.par_en ? RX_PAR : RX_STOP;
                            d.stop2 = 1'b0;
                        end else begin
                            d.idx = q.idx + IW'(1);
                        end
                    end else begin
                        d.cnt = q.cnt + CNTW'(1);
                    end
                end
                RX_PAR: begin
                    if (q.cnt == LAST) begin
                        d.cnt   = '0;
                        d.perr  = rxs ^ q.par ^ q.cfg.par_odd;
                        d.st    = RX_STOP;
                        d.stop2 = 1'b0;
                    end else begin
                        d.cnt = q.cnt + CNTW'(1);
                    end
                end
                RX_STOP: begin
                    if (q.cnt == LAST) begin
                        d.cnt  = '0;
                        d.ferr = q.ferr | !rxs;
                        if (q.cfg.two_stop && !q.stop2) begin
                            d.stop2 = 1'b1;
                        end else begin
                            d.push = 1'b1;
                            d.st   = rxs ? RX_IDLE : RX_HOLD;
                        end
                    end else begin
                        d.cnt = q.cnt + CNTW'(1);
                    end
                end
                RX_HOLD: begin
                    if (rxs) d.st = RX_IDLE;
                end
                default: d = RX_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RX_RST;
        else        q <= d;
    end

    assign push = q.push;
    assign data = q.data;
    assign perr = q.perr;
    assign ferr = q.ferr;
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
    import uart_fe_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_tick,
    input  logic                     os_tick,
    input  logic [CTRL_MSB:CTRL_LSB] ctrl_bits,
    input  logic                     cts,
    input  logic                     tx_empty,
    input  logic [CHAR_W-1:0]        tx_data,
    output logic                     tx_pop,
    output logic                     txd,
    output logic                     tx_busy,
    input  logic                     rxd,
    output logic                     rx_push,
    output logic [CHAR_W-1:0]        rx_data,
    output logic                     rx_perr,
    output logic                     rx_ferr
);
    frame_cfg_t cfg;
    logic       flow_ok;

    uart_fe_ctrl u_ctrl (
        .ctrl_bits (ctrl_bits),
        .cts       (cts),
        .cfg       (cfg),
        .flow_ok   (flow_ok)
    );

    uart_fe_tx #(.DW(CHAR_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .cfg_i      (cfg),
        .flow_ok    (flow_ok),
        .fifo_empty (tx_empty),
        .fifo_data  (tx_data),
        .fifo_pop   (tx_pop),
        .txd        (txd),
        .busy       (tx_busy)
    );

    uart_fe_rx #(.DW(CHAR_W), .OS(OS_RATE), .SYNC(SYNC_STAGES)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .rxd     (rxd),
        .cfg_i   (cfg),
        .push    (rx_push),
        .data    (rx_data),
        .perr    (rx_perr),
        .ferr    (rx_ferr)
    );
endmodule

// File: rtl/uart_fe_chk.sv
module uart_fe_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic tx_empty,
    input logic cts,
    input logic two_wire,
    input logic tx_pop,
    input logic txd,
    input logic tx_busy,
    input logic rx_push
);
    p_idle_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> $stable(txd));

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);

    p_pop_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (bit_tick && !tx_empty));

    p_busy_from_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(tx_pop));

    p_flow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && !two_wire) |-> cts);

    p_push_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);
endmodule

bind uart_frame_engine uart_fe_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .tx_empty (tx_empty),
    .cts      (cts),
    .two_wire (ctrl_bits[15]),
    .tx_pop   (tx_pop),
    .txd      (txd),
    .tx_busy  (tx_busy),
    .rx_push  (rx_push)
);

// File: tb/sim_uart_frame_engine.sv
module sim_uart_frame_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        os_tick = 1'b0;
    logic [21:15] ctrl_bits = '0;
    logic        cts = 1'b1;
    logic        tx_empty = 1'b1;
    logic [7:0]  tx_data = '0;
    logic        tx_pop, txd, tx_busy;
    logic        rxd = 1'b1;
    logic        rx_push, rx_perr, rx_ferr;
    logic [7:0]  rx_data;

    always #5 clk = ~clk;

    uart_frame_engine u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .os_tick(os_tick),
        .ctrl_bits(ctrl_bits), .cts(cts), .tx_empty(tx_empty), .tx_data(tx_data),
        .tx_pop(tx_pop), .txd(txd), .tx_busy(tx_busy), .rxd(rxd),
        .rx_push(rx_push), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit armed   = 1'b0;
    string cur_req = "R1";

    // behavioural model state
    logic [7:0] tx_q[$];
    bit         m_bits[$];
    bit         m_txd  = 1'b1;
    bit         m_busy = 1'b0;
    bit         rx_wave[$];
    logic [7:0] rx_exp_d[$];
    bit         rx_exp_pe[$];
    bit         rx_exp_fe[$];
    string      rx_exp_req[$];

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [21:15] mk(input logic [1:0] len, input logic pen,
                                        input logic podd, input logic [1:0] stp,
                                        input logic tw);
        return {len, pen, podd, stp, tw};
    endfunction

    task automatic cycle();
        bit exp_pop;
        logic [7:0] ch;
        bit p;
        int nb;
        string r;
        @(negedge clk);
        if (armed) begin
            chk(cur_req, txd, m_txd, "txd");
            chk("R5", tx_busy, m_busy, "tx_busy");
            if (rx_push) begin
                if (rx_exp_d.size() == 0) begin
                    chk(cur_req, 1, 0, "unexpected rx_push");
                end else begin
                    r = rx_exp_req.pop_front();
                    chk(r, rx_data, rx_exp_d.pop_front(), "rx_data");
                    chk(r, rx_perr, rx_exp_pe.pop_front(), "rx_perr");
                    chk(r, rx_ferr, rx_exp_fe.pop_front(), "rx_ferr");
                end
            end
        end
        os_tick  = (cyc % 2) == 0;
        bit_tick = (cyc % 32) == 0;
        cyc++;
        tx_empty = (tx_q.size() == 0);
        tx_data  = (tx_q.size() != 0) ? tx_q[0] : 8'h00;
        rxd      = (rx_wave.size() != 0) ? rx_wave.pop_front() : 1'b1;
        #1;
        exp_pop = rst_n && bit_tick && (m_bits.size() == 0) && (tx_q.size() != 0)
                  && (ctrl_bits[15] || cts);
        if (armed) chk((cur_req == "R6") ? "R6" : "R5", tx_pop, exp_pop, "tx_pop");
        if (rst_n && bit_tick) begin
            if (m_bits.size() != 0) begin
                m_txd  = m_bits.pop_front();
                m_busy = 1'b1;
            end else if (exp_pop) begin
                ch = tx_q.pop_front();
                nb = 8 - int'(ctrl_bits[21:20]);
                p  = 1'b0;
                m_bits.push_back(1'b0);
                for (int i = 0; i < nb; i++) begin
                    m_bits.push_back(ch[i]);
                    p ^= ch[i];
                end
                if (ctrl_bits[19]) m_bits.push_back(p ^ ctrl_bits[18]);
                m_bits.push_back(1'b1);
                if (ctrl_bits[17:16] != 2'b00) m_bits.push_back(1'b1);
                m_txd  = m_bits.pop_front();
                m_busy = 1'b1;
            end else begin
                m_txd  = 1'b1;
                m_busy = 1'b0;
            end
        end
        armed = rst_n;
    endtask

    task automatic lvl(input bit b, input int clocks);
        for (int i = 0; i < clocks; i++) rx_wave.push_back(b);
    endtask

    // Queue one receive frame using the current control slice.
    task automatic send_rx(input logic [7:0] dat, input bit flip_par,
                           input bit low_stop, input string req);
        int nb = 8 - int'(ctrl_bits[21:20]);
        bit p = 1'b0;
        logic [7:0] mask = 8'((1 << nb) - 1);
        lvl(1'b0, 32);
        for (int i = 0; i < nb; i++) begin
            lvl(dat[i], 32);
            p ^= dat[i];
        end
        if (ctrl_bits[19]) lvl(p ^ ctrl_bits[18] ^ flip_par, 32);
        lvl(!low_stop, 32);
        if (ctrl_bits[17:16] != 2'b00) lvl(1'b1, 32);
        lvl(1'b1, 64);
        rx_exp_d.push_back(dat & mask);
        rx_exp_pe.push_back(ctrl_bits[19] && flip_par);
        rx_exp_fe.push_back(low_stop);
        rx_exp_req.push_back(req);
    endtask

    task automatic drain();
        int g = 0;
        while (!(m_bits.size() == 0 && !m_busy && tx_q.size() == 0 &&
                 rx_wave.size() == 0 && rx_exp_d.size() == 0) && g < 20000) begin
            cycle();
            g++;
        end
        chk(cur_req, (g < 20000), 1, "phase drained");
        repeat (40) cycle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        ctrl_bits = mk(2'b00, 1'b0, 1'b0, 2'b00, 1'b1);
        repeat (4) cycle();
        rst_n = 1'b1;
        cycle();
        // R1: state right after reset
        chk("R1", txd, 1, "txd after reset");
        chk("R1", tx_busy, 0, "busy after reset");
        chk("R1", tx_pop, 0, "pop after reset");
        chk("R1", rx_push, 0, "push after reset");
        repeat (40) cycle();

        // R2 / R7: 8 data bits, no parity, one stop; back-to-back (R5)
        cur_req = "R2";
        tx_q.push_back(8'hA5);
        tx_q.push_back(8'h3C);
        send_rx(8'h5A, 1'b0, 1'b0, "R7");
        drain();

        // R2 / R7: 5 data bits, upper bits ignored / zero
        cur_req = "R2";
        ctrl_bits = mk(2'b11, 1'b0, 1'b0, 2'b00, 1'b1);
        tx_q.push_back(8'hF3);
        send_rx(8'hF3, 1'b0, 1'b0, "R7");
        drain();

        // R3 / R8: 7 bits even parity, then 6 bits odd parity
        cur_req = "R3";
        ctrl_bits = mk(2'b01, 1'b1, 1'b0, 2'b00, 1'b1);
        tx_q.push_back(8'h55);
        tx_q.push_back(8'h07);
        send_rx(8'h6B, 1'b0, 1'b0, "R7");
        send_rx(8'h6B, 1'b1, 1'b0, "R8");
        drain();
        ctrl_bits = mk(2'b10, 1'b1, 1'b1, 2'b00, 1'b1);
        tx_q.push_back(8'h2A);
        send_rx(8'h15, 1'b0, 1'b0, "R8");
        send_rx(8'h15, 1'b1, 1'b0, "R8");
        drain();

        // R4: two stop bits, stop field 01 and 11
        cur_req = "R4";
        ctrl_bits = mk(2'b00, 1'b0, 1'b0, 2'b01, 1'b1);
        tx_q.push_back(8'h81);
        tx_q.push_back(8'h7E);
        send_rx(8'hC3, 1'b0, 1'b0, "R7");
        drain();
        ctrl_bits = mk(2'b00, 1'b1, 1'b1, 2'b11, 1'b1);
        tx_q.push_back(8'h0F);
        drain();

        // R6: flow control honoured, then ignored in two-wire mode
        cur_req = "R6";
        ctrl_bits = mk(2'b00, 1'b0, 1'b0, 2'b00, 1'b0);
        cts = 1'b0;
        tx_q.push_back(8'h99);
        repeat (200) cycle();
        chk("R6", tx_busy, 0, "busy while cts low");
        chk("R6", txd, 1, "line while cts low");
        cts = 1'b1;
        drain();
        ctrl_bits = mk(2'b00, 1'b0, 1'b0, 2'b00, 1'b1);
        cts = 1'b0;
        tx_q.push_back(8'h42);
        repeat (40) cycle();
        chk("R6", tx_busy, 1, "two-wire ignores cts");
        drain();
        cts = 1'b1;

        // R9: low stop bit, then a break, then a clean frame
        cur_req = "R9";
        send_rx(8'h3D, 1'b0, 1'b1, "R9");
        drain();
        lvl(1'b0, 12 * 32);
        lvl(1'b1, 64);
        rx_exp_d.push_back(8'h00);
        rx_exp_pe.push_back(1'b0);
        rx_exp_fe.push_back(1'b1);
        rx_exp_req.push_back("R9");
        send_rx(8'hE7, 1'b0, 1'b0, "R9");
        drain();

        // R10: short low glitch is not a start bit
        cur_req = "R10";
        lvl(1'b0, 8);
        lvl(1'b1, 96);
        repeat (200) cycle();
        chk("R10", rx_exp_d.size(), 0, "no push after glitch");
        send_rx(8'h96, 1'b0, 1'b0, "R10");
        drain();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule